// File: doc/BRIEF.md
# CAN Receive Queue with Acceptance Filtering

This block sits behind a CAN protocol engine that has already decoded a frame. Each frame arrives as a one-cycle strobe carrying the identifier, the extended-format flag, the remote-request flag, the length code and eight data bytes. The frame is compared in parallel against an eight-entry acceptance table. Either one shared mask or a private mask per entry selects which bits must agree. An accepted frame is written into a six-slot queue, together with the number of the entry that accepted it.

Software sees the block through a word-addressed register bus. The oldest stored frame is always presented in the same four-word read window. Three status flags report that frames are waiting, that the queue is nearly full and that an accepted frame was lost. Software writes 1 to the frames-waiting flag to retire the head frame, and the next frame then appears in the window.

Top module: `canRxQueue`

## Requirements
- R1: After reset the status word reads 0, the control word reads 0 (shared-mask mode), the shared mask and all eight private masks read 0xFFFFFFFF, and all table entries read 0.
- R2: A frame is turned into a 32-bit compare word: bit 31 = RTR, bit 30 = IDE, and the identifier in bits 29:1 (extended, 29 bits) or bits 29:19 (standard, 11 bits, bits 18:0 zero). An entry matches when every bit set in the active mask is equal in the compare word and the entry. Table entry k is at word address 8+k and uses the same layout.
- R3: In shared-mask mode (control bit 0 = 0) the mask at word address 2 applies to every entry. A mask of 0x7FFFFFFE lets a frame match regardless of its RTR bit.
- R4: In per-entry mode (control bit 0 = 1) entry k uses the mask at word address 16+k, and the shared mask has no effect.
- R5: A frame that matches no entry is not stored and changes no flag.
- R6: Frames leave in arrival order through window words 4..7. Word 4 holds the DLC in bits 3:0, RTR in bit 4, IDE in bit 5 and the hit index in bits 10:8. Word 5 holds the identifier in bits 28:0. Word 6 holds data bytes 0..3 and word 7 holds bytes 4..7, with byte 0 in bits 7:0.
- R7: When several entries match, the hit index is that of the lowest-numbered matching entry.
- R8: Status bit 0 (frames waiting) is 1 whenever the queue holds at least one frame. Writing 1 to it retires the head frame. Writing 0, or writing 1 while the queue is empty, changes nothing.
- R9: Status bit 1 (nearly full) is 1 exactly while 5 or more frames are stored.
- R10: An accepted frame that arrives while 6 frames are stored, with no retire in the same cycle, is discarded. It sets status bit 2 (overflow), which stays set until software writes 1 to bit 2, and the stored frames are left unchanged.
- R11: While the queue is empty, all four window words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frmValid | input | 1 | One-cycle strobe: a decoded frame is present |
| frmId | input | 29 | Identifier (standard frames use bits 10:0) |
| frmIde | input | 1 | Extended-format flag |
| frmRtr | input | 1 | Remote-request flag |
| frmDlc | input | 4 | Data length code |
| frmData | input | 64 | Data bytes, byte 0 in bits 7:0 |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 5 | Register word address |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data for busAddr (combinational) |
| statusAvail | output | 1 | Frames waiting flag |
| statusAlmostFull | output | 1 | Nearly full flag |
| statusOverflow | output | 1 | Sticky overflow flag |

## Verification
The hardest state to reach from the ports is a full queue that receives one more accepted frame. This needs six matching frames without a retire in between, followed by a seventh, and then a check that the head is still the first frame. A directed sequence fills the queue on purpose. It watches the nearly-full flag rise on the fifth frame, overruns on the seventh, clears overflow on its own, and then drains the queue. A long random phase follows. It programs tables in both mask modes from a small pool of identifiers so that matches, misses and ties between entries are all common. Frames and retires are mixed at a ratio that repeatedly fills and drains the queue.

// File: rtl/canRxQueuePkg.sv
package canRxQueuePkg;

  localparam int ADDR_W = 5;
  typedef logic [ADDR_W-1:0] regAddrT;

  // Word addresses (the table and mask blocks hold up to 8 entries)
  localparam regAddrT A_CTRL   = 5'd0;
  localparam regAddrT A_STATUS = 5'd1;
  localparam regAddrT A_GMASK  = 5'd2;
  localparam regAddrT A_WIN    = 5'd4;
  localparam regAddrT A_TBL    = 5'd8;
  localparam regAddrT A_MSK    = 5'd16;

  typedef struct packed {
    logic [28:0] id;
    logic        ide;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
  } canFrameT;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } queueStrobeT;

  function automatic logic [31:0] packFrame(input logic [28:0] id,
                                            input logic ide,
                                            input logic rtr);
    if (ide) return {rtr, 1'b1, id, 1'b0};
    return {rtr, 1'b0, id[10:0], 18'b0, 1'b0};
  endfunction

endpackage

// File: rtl/canRxQueueMatch.sv
module canRxQueueMatch #(
  parameter int NUM_ENTRIES = 8,
  localparam int HIT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [31:0]                  frameWord,
  input  logic [NUM_ENTRIES-1:0][31:0] entryWord,
  input  logic [NUM_ENTRIES-1:0][31:0] entryMask,
  input  logic [31:0]                  sharedMask,
  input  logic                         perEntryMode,
  output logic                         hitAny,
  output logic [HIT_W-1:0]             hitIdx
);

  logic [NUM_ENTRIES-1:0] entryHit;

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : gCmp
    logic [31:0] activeMask;
    assign activeMask  = perEntryMode ? entryMask[k] : sharedMask;
    assign entryHit[k] = ((frameWord ^ entryWord[k]) & activeMask) == 32'd0;
  end

  // Lowest-numbered hit wins: scan downward so the last assignment is the lowest
  always_comb begin
    hitIdx = '0;
    for (int k = NUM_ENTRIES - 1; k >= 0; k--) begin
      if (entryHit[k]) hitIdx = HIT_W'(k);
    end
  end

  assign hitAny = |entryHit;

endmodule

// File: rtl/canRxQueueCtrl.sv
module canRxQueueCtrl
  import canRxQueuePkg::*;
#(
  parameter int DEPTH       = 6,
  parameter int AFULL_LEVEL = 5,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameAccepted,
  input  logic              popReq,
  input  logic              ovfClr,
  output queueStrobeT       strb,
  output logic [SLOT_W-1:0] wrSlot,
  output logic [SLOT_W-1:0] rdSlot,
  output logic [CNT_W-1:0]  fillLevel,
  output logic              avail,
  output logic              almostFull,
  output logic              overflow
);

  logic isFull;
  logic popOk;
  logic pushOk;

  assign isFull = fillLevel == CNT_W'(DEPTH);
  assign avail  = fillLevel != '0;
  assign popOk  = popReq && avail;
  // A retire in the same cycle frees a slot for a frame arriving at a full queue
  assign pushOk = frameAccepted && (!isFull || popOk);

  assign strb.push = pushOk;
  assign strb.pop  = popOk;

  assign almostFull = fillLevel >= CNT_W'(AFULL_LEVEL);

  function automatic logic [SLOT_W-1:0] nextSlot(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(DEPTH - 1)) ? '0 : s + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrSlot    <= '0;
      rdSlot    <= '0;
      fillLevel <= '0;
      overflow  <= 1'b0;
    end else begin
      if (pushOk) wrSlot <= nextSlot(wrSlot);
      if (popOk)  rdSlot <= nextSlot(rdSlot);
      case ({pushOk, popOk})
        2'b10:   fillLevel <= fillLevel + 1'b1;
        2'b01:   fillLevel <= fillLevel - 1'b1;
        default: fillLevel <= fillLevel;
      endcase
      if (frameAccepted && !pushOk) overflow <= 1'b1;
      else if (ovfClr)              overflow <= 1'b0;
    end
  end

endmodule

// File: rtl/canRxQueueData.sv
module canRxQueueData
  import canRxQueuePkg::*;
#(
  parameter int DEPTH       = 6,
  parameter int NUM_ENTRIES = 8,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int HIT_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frmValid,
  input  canFrameT          frmIn,
  input  logic              busWr,
  input  regAddrT           busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  queueStrobeT       strb,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [SLOT_W-1:0] rdSlot,
  input  logic              avail,
  input  logic              almostFull,
  input  logic              overflow,
  output logic              frameAccepted,
  output logic              popReq,
  output logic              ovfClr
);

  logic                         perEntryMode;
  logic [31:0]                  sharedMask;
  logic [NUM_ENTRIES-1:0][31:0] entryWord;
  logic [NUM_ENTRIES-1:0][31:0] entryMask;
  logic                         hitAny;
  logic [HIT_W-1:0]             hitIdx;

  canFrameT         slotFrm [DEPTH];
  logic [HIT_W-1:0] slotHit [DEPTH];

  logic statusWr;

  canRxQueueMatch #(.NUM_ENTRIES(NUM_ENTRIES)) uMatch (
    .frameWord   (packFrame(frmIn.id, frmIn.ide, frmIn.rtr)),
    .entryWord   (entryWord),
    .entryMask   (entryMask),
    .sharedMask  (sharedMask),
    .perEntryMode(perEntryMode),
    .hitAny      (hitAny),
    .hitIdx      (hitIdx)
  );

  assign frameAccepted = frmValid && hitAny;
  assign statusWr      = busWr && (busAddr == A_STATUS);
  assign popReq        = statusWr && busWrData[0];
  assign ovfClr        = statusWr && busWrData[2];

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      perEntryMode <= 1'b0;
      sharedMask   <= '1;
      entryWord    <= '0;
      entryMask    <= '1;
    end else if (busWr) begin
      if (busAddr == A_CTRL)  perEntryMode <= busWrData[0];
      if (busAddr == A_GMASK) sharedMask   <= busWrData;
      for (int k = 0; k < NUM_ENTRIES; k++) begin
        if (busAddr == regAddrT'(A_TBL + k)) entryWord[k] <= busWrData;
        if (busAddr == regAddrT'(A_MSK + k)) entryMask[k] <= busWrData;
      end
    end
  end

  // Frame storage, written at the slot the control picks
  always_ff @(posedge clk) begin
    if (strb.push) begin
      slotFrm[wrSlot] <= frmIn;
      slotHit[wrSlot] <= hitIdx;
    end
  end

  canFrameT         headFrm;
  logic [HIT_W-1:0] headHit;
  assign headFrm = slotFrm[rdSlot];
  assign headHit = slotHit[rdSlot];

  // Read path
  always_comb begin
    busRdData = '0;
    if (busAddr == A_CTRL) begin
      busRdData = {31'b0, perEntryMode};
    end else if (busAddr == A_STATUS) begin
      busRdData = {29'b0, overflow, almostFull, avail};
    end else if (busAddr == A_GMASK) begin
      busRdData = sharedMask;
    end else if ((busAddr >= A_WIN) && (busAddr < regAddrT'(A_WIN + 4))) begin
      if (avail) begin
        case (busAddr[1:0])
          2'd0:    busRdData = {21'b0, 3'(headHit), 2'b0, headFrm.ide,
                                headFrm.rtr, headFrm.dlc};
          2'd1:    busRdData = {3'b0, headFrm.id};
          2'd2:    busRdData = headFrm.data[31:0];
          default: busRdData = headFrm.data[63:32];
        endcase
      end
    end else begin
      for (int k = 0; k < NUM_ENTRIES; k++) begin
        if (busAddr == regAddrT'(A_TBL + k)) busRdData = entryWord[k];
        if (busAddr == regAddrT'(A_MSK + k)) busRdData = entryMask[k];
      end
    end
  end

endmodule

// File: rtl/canRxQueue.sv
module canRxQueue
  import canRxQueuePkg::*;
#(
  parameter int DEPTH       = 6,
  parameter int NUM_ENTRIES = 8,
  parameter int AFULL_LEVEL = 5,
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frmValid,
  input  logic [28:0] frmId,
  input  logic        frmIde,
  input  logic        frmRtr,
  input  logic [3:0]  frmDlc,
  input  logic [63:0] frmData,
  input  logic        busWr,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        statusAvail,
  output logic        statusAlmostFull,
  output logic        statusOverflow
);

  queueStrobeT       strb;
  logic [SLOT_W-1:0] wrSlot;
  logic [SLOT_W-1:0] rdSlot;
  logic [CNT_W-1:0]  fillLevel;
  logic              frameAccepted;
  logic              popReq;
  logic              ovfClr;
  canFrameT          frmIn;

  assign frmIn = '{id: frmId, ide: frmIde, rtr: frmRtr, dlc: frmDlc, data: frmData};

  canRxQueueCtrl #(.DEPTH(DEPTH), .AFULL_LEVEL(AFULL_LEVEL)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameAccepted(frameAccepted),
    .popReq       (popReq),
    .ovfClr       (ovfClr),
    .strb         (strb),
    .wrSlot       (wrSlot),
    .rdSlot       (rdSlot),
    .fillLevel    (fillLevel),
    .avail        (statusAvail),
    .almostFull   (statusAlmostFull),
    .overflow     (statusOverflow)
  );

  canRxQueueData #(.DEPTH(DEPTH), .NUM_ENTRIES(NUM_ENTRIES)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .frmValid     (frmValid),
    .frmIn        (frmIn),
    .busWr        (busWr),
    .busAddr      (busAddr),
    .busWrData    (busWrData),
    .busRdData    (busRdData),
    .strb         (strb),
    .wrSlot       (wrSlot),
    .rdSlot       (rdSlot),
    .avail        (statusAvail),
    .almostFull   (statusAlmostFull),
    .overflow     (statusOverflow),
    .frameAccepted(frameAccepted),
    .popReq       (popReq),
    .ovfClr       (ovfClr)
  );

endmodule

// File: rtl/canRxQueueChk.sv
module canRxQueueChk
  import canRxQueuePkg::*;
#(
  parameter int DEPTH       = 6,
  parameter int AFULL_LEVEL = 5,
  parameter int CNT_W       = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             frmValid,
  input logic             busWr,
  input logic [4:0]       busAddr,
  input logic [31:0]      busWrData,
  input logic [31:0]      busRdData,
  input logic             statusAvail,
  input logic             statusAlmostFull,
  input logic             statusOverflow,
  input logic [CNT_W-1:0] fillLevel
);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CNT_W'(DEPTH)); // R10

  AST_AFULL_NEEDS_AVAIL: assert property (@(posedge clk) disable iff (!rstN)
    statusAlmostFull |-> statusAvail); // R9

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!frmValid && !(busWr && busAddr == A_STATUS)) |=> $stable(fillLevel)); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statusOverflow && !(busWr && busAddr == A_STATUS && busWrData[2]))
      |=> statusOverflow); // R10

  AST_OVF_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusOverflow) |-> $past(fillLevel) == CNT_W'(DEPTH)); // R10

  AST_DROP_NO_GROWTH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == CNT_W'(DEPTH)) |=> fillLevel <= CNT_W'(DEPTH)); // R10

  AST_EMPTY_WINDOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!statusAvail && busAddr >= A_WIN && busAddr < 5'(A_WIN + 4))
      |-> busRdData == 32'd0); // R11

endmodule

bind canRxQueue canRxQueueChk #(
  .DEPTH(DEPTH), .AFULL_LEVEL(AFULL_LEVEL), .CNT_W(CNT_W)
) uChk (
  .clk             (clk),
  .rstN            (rstN),
  .frmValid        (frmValid),
  .busWr           (busWr),
  .busAddr         (busAddr),
  .busWrData       (busWrData),
  .busRdData       (busRdData),
  .statusAvail     (statusAvail),
  .statusAlmostFull(statusAlmostFull),
  .statusOverflow  (statusOverflow),
  .fillLevel       (fillLevel)
);

// File: tb/canRxQueue_test.sv
`timescale 1ns/1ps
module canRxQueue_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frmValid = 1'b0;
  logic [28:0] frmId = '0;
  logic        frmIde = 1'b0;
  logic        frmRtr = 1'b0;
  logic [3:0]  frmDlc = '0;
  logic [63:0] frmData = '0;
  logic        busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        statusAvail, statusAlmostFull, statusOverflow;

  always #2.5 clk = ~clk;

  canRxQueue uut (.*);

  int nChecks = 0;
  int nFails  = 0;

  // Bench model of the requirements
  logic [31:0] mTbl [8];
  logic [31:0] mMsk [8];
  logic [31:0] mGMask;
  logic        mMode;
  logic [28:0] qId   [6];
  logic        qIde  [6];
  logic        qRtr  [6];
  logic [3:0]  qDlc  [6];
  logic [63:0] qData [6];
  int          qHit  [6];
  int          qCnt;
  logic        mOvf;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [28:0] id, input logic ide,
                                       input logic rtr);
    return ide ? {rtr, 1'b1, id, 1'b0} : {rtr, 1'b0, id[10:0], 18'b0, 1'b0};
  endfunction

  function automatic int modelHit(input logic [28:0] id, input logic ide,
                                  input logic rtr);
    logic [31:0] w = word(id, ide, rtr);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] m = mMode ? mMsk[k] : mGMask;
      if (((w ^ mTbl[k]) & m) == 0) return k;
    end
    return -1;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 8; k++) begin mTbl[k] = 0; mMsk[k] = '1; end
    mGMask = '1; mMode = 0; qCnt = 0; mOvf = 0;
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 0;
    if (a == 0) mMode = d[0];
    if (a == 2) mGMask = d;
    if (a >= 8 && a < 16) mTbl[a-8] = d;
    if (a >= 16 && a < 24) mMsk[a-16] = d;
    if (a == 1) begin
      if (d[0] && qCnt > 0) begin
        for (int i = 0; i < 5; i++) begin
          qId[i] = qId[i+1]; qIde[i] = qIde[i+1]; qRtr[i] = qRtr[i+1];
          qDlc[i] = qDlc[i+1]; qData[i] = qData[i+1]; qHit[i] = qHit[i+1];
        end
        qCnt--;
      end
      if (d[2]) mOvf = 0;
    end
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic sendFrame(input logic [28:0] id, input logic ide, input logic rtr,
                           input logic [3:0] dlc, input logic [63:0] data);
    int h;
    @(negedge clk);
    frmValid = 1; frmId = id; frmIde = ide; frmRtr = rtr; frmDlc = dlc; frmData = data;
    @(negedge clk);
    frmValid = 0;
    h = modelHit(id, ide, rtr);
    if (h >= 0) begin
      if (qCnt == 6) mOvf = 1;
      else begin
        qId[qCnt] = id; qIde[qCnt] = ide; qRtr[qCnt] = rtr;
        qDlc[qCnt] = dlc; qData[qCnt] = data; qHit[qCnt] = h; qCnt++;
      end
    end
  endtask

  task automatic checkStatus(input string tag);
    logic [31:0] d, e;
    busRead(5'd1, d);
    e = {29'b0, mOvf, qCnt >= 5, qCnt > 0};
    check(d == e, {tag, " R8 R9 R10 status word"}, d, e);
    check({statusOverflow, statusAlmostFull, statusAvail} == e[2:0],
          {tag, " R8 R9 R10 status pins"},
          {29'b0, statusOverflow, statusAlmostFull, statusAvail}, e);
  endtask

  task automatic checkWindow(input string tag);
    logic [31:0] d, e;
    for (int w = 0; w < 4; w++) begin
      busRead(5'(4 + w), d);
      if (qCnt == 0) e = 0;
      else case (w)
        0: e = {21'b0, 3'(qHit[0]), 2'b0, qIde[0], qRtr[0], qDlc[0]};
        1: e = {3'b0, qId[0]};
        2: e = qData[0][31:0];
        default: e = qData[0][63:32];
      endcase
      check(d == e, {tag, (qCnt == 0) ? " R11 empty window" : " R6 R7 window"}, d, e);
    end
  endtask

  task automatic popChecked(input string tag);
    checkWindow(tag);
    busWrite(5'd1, 32'h1);
    checkStatus(tag);
  endtask

  function automatic logic [28:0] pickId(input logic ide);
    logic [28:0] pool [4] = '{29'h1234567, 29'h1FFFFFFF, 29'h0ABCDEF, 29'h0000123};
    logic [28:0] v = pool[$urandom % 4];
    if ($urandom % 3 == 0) v = v ^ 29'($urandom % 16);
    return ide ? v : {18'b0, v[10:0]};
  endfunction

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected 0 (run hung)", 1);
    finishRun();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED));
    modelReset();
    repeat (4) @(negedge clk);
    rstN = 1;

    // R1 reset state
    busRead(5'd0, d);  check(d == 0, "R1 ctrl", d, 0);
    busRead(5'd2, d);  check(d == '1, "R1 shared mask", d, '1);
    busRead(5'd17, d); check(d == '1, "R1 entry mask", d, '1);
    busRead(5'd12, d); check(d == 0, "R1 table entry", d, 0);
    checkStatus("R1");
    checkWindow("R1");

    // R2 default table matches a standard data frame with id 0; R5 other id dropped
    sendFrame(29'h0, 0, 0, 4'd8, 64'h8877665544332211);
    checkStatus("R2");
    popChecked("R2");
    sendFrame(29'h1, 0, 0, 4'd2, 64'h55);
    checkStatus("R5");

    // R3 shared mask ignoring RTR
    busWrite(5'd2, 32'h7FFFFFFE);
    busWrite(5'd8, word(29'h7FF, 0, 0));
    for (int k = 1; k < 8; k++) busWrite(5'(8 + k), word(29'h1FFFFFFF, 1, 1));
    sendFrame(29'h7FF, 0, 1, 4'd0, 64'h0);
    sendFrame(29'h1FFC0000, 1, 0, 4'd1, 64'hAA);   // R5 IDE differs
    sendFrame(29'h1FFFFFFF, 1, 0, 4'd3, 64'hCCBBAA);
    checkStatus("R3");
    popChecked("R3");
    popChecked("R3");

    // R4 per-entry masks
    busWrite(5'd0, 32'h1);
    busWrite(5'd11, word(29'h1234560, 1, 0));
    busWrite(5'd19, 32'hFFFFFFE1);
    sendFrame(29'h123456A, 1, 0, 4'd5, 64'h1122334455);
    sendFrame(29'h7FF, 0, 1, 4'd0, 64'h0);         // R4 RTR now checked
    checkStatus("R4");
    popChecked("R4");

    // R7 two entries tie
    busWrite(5'd10, word(29'h0ABCDEF, 1, 0));
    busWrite(5'd13, word(29'h0ABCDEF, 1, 0));
    sendFrame(29'h0ABCDEF, 1, 0, 4'd7, 64'hDEADBEEF);
    popChecked("R7");

    // R9 R10 fill, overrun, clear
    for (int i = 0; i < 7; i++) begin
      sendFrame(29'h0ABCDEF, 1, 0, 4'(i), 64'(i * 3 + 1));
      checkStatus("R9 R10 fill");
    end
    checkWindow("R10 head kept");
    busWrite(5'd1, 32'h0);
    checkStatus("R8 write zero");
    busWrite(5'd1, 32'h4);
    checkStatus("R10 clear");
    while (qCnt > 0) popChecked("R8 drain");
    busWrite(5'd1, 32'h1);
    checkStatus("R8 pop empty");
    checkWindow("R11");

    // Random phase
    for (int round = 0; round < 6; round++) begin
      busWrite(5'd0, 32'($urandom % 2));
      busWrite(5'd2, ($urandom % 2) ? 32'h7FFFFFFE : 32'hFFFFFFE1);
      for (int k = 0; k < 8; k++) begin
        logic ide = 1'($urandom % 2);
        logic [31:0] mk [3] = '{32'hFFFFFFFF, 32'h7FFFFFFE, 32'hFFE7FFE1};
        busWrite(5'(8 + k), word(pickId(ide), ide, 1'($urandom % 2)));
        busWrite(5'(16 + k), mk[$urandom % 3]);
      end
      for (int op = 0; op < 120; op++) begin
        int r = $urandom % 10;
        if (r < 6) begin
          logic ide = 1'($urandom % 2);
          sendFrame(pickId(ide), ide, 1'($urandom % 2), 4'($urandom % 9),
                    {$urandom, $urandom});
          checkStatus("R2 R3 R4 random");
        end else if (r < 9) begin
          popChecked("R6 random");
        end else begin
          busWrite(5'd1, 32'h4);
          checkStatus("R10 random clear");
        end
      end
    end
    finishRun();
  end

endmodule